// File: doc/BRIEF.md
# Fire Cell Sweep Engine

This block advances a heat-diffusion cellular automaton that lives in an external single-port cell RAM. A pulse on `start` begins one frame of work: first the source row near the bottom of the matrix is filled with fresh pseudo-random heat values. Then every interior cell is overwritten with the cooled mean of four cells lying beneath it. The engine owns the RAM port for the whole frame and signals completion with a one-cycle `done` pulse.

The matrix is padded by one column on the right and one row at the bottom, so each row holds `W+1` cells and there are `H+1` rows. Cell (y,x) lives at word address `y*(W+1)+x`, and each word is 8 bits. The active width `W` and height `H` come from configuration inputs that are captured when a frame starts. The RAM is expected to return read data one clock after the address is presented.

Top module: `heat_cascade_engine`

## Requirements
- R1: A swept cell's new value is derived from S = (y+1,x-1) + (y+1,x) + (y+1,x+1) + (y+2,x), summed without loss as a 10-bit value (up to 1020), then divided by four by shifting right by 2.
- R2: When S>>2 is nonzero the stored value is (S>>2)-1; when it is zero the stored value is 0, so no written sweep value ever exceeds 254.
- R3: The sweep writes only rows 0..H-2 and columns 1..W-1; column 0, column W, row H and every address beyond (H+1)*(W+1)-1 are left unchanged. The seed row H-1 is changed only by seeding.
- R4: Cell (y,x) is accessed at address y*(W+1)+x, with one 8-bit value per address.
- R5: Before the sweep, row H-1, columns 1..W-1, is written in ascending column order. Each value is the low 7 bits of a 16-bit generator state, zero-extended. The generator then steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The generator holds 16'hACE1 after reset and keeps its state from one frame to the next.
- R6: Swept cells are written in ascending address order (row by row from row 0, columns ascending), in place, after the seed writes.
- R7: Read data is taken one cycle after its address. Seeding takes one cycle per cell, and the sweep takes five cycles per cell (four reads, one write). `done` is high in cycle (W-1) + 5*(W-1)*(H-1) + 1, counted from the clock edge that samples `start`.
- R8: `done` is a single-cycle pulse in the cycle after the last write of the frame.
- R9: `start` is ignored while a frame is in progress: the frame finishes exactly as if no extra pulse arrived, and only one `done` pulse follows.
- R10: After reset, `done` and `mem_we` are low and no RAM writes happen until `start`. Configurations need W>=2 and H>=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (seed, then sweep); ignored while busy |
| cfg_width | input | DIM_W (9) | Active width W; the row stride is W+1 |
| cfg_height | input | DIM_W (9) | Active height H; rows 0..H are stored |
| done | output | 1 | One-cycle pulse after the frame's last write |
| mem_addr | output | ADDR_W (15) | Cell RAM word address |
| mem_wdata | output | 8 | Cell RAM write data |
| mem_we | output | 1 | Cell RAM write enable |
| mem_rdata | input | 8 | Cell RAM read data, valid one cycle after the address |

## Verification
Each frame's RAM contents are predicted in full by an arithmetic model of seeding and sweeping. This catches a wrong neighbour tap, a missing cool-down, an averaged zero turned into 255, or a sum truncated to 8 bits. Saturated cells (all 255) reach the 1020 sum that only a 10-bit accumulator holds. All-zero fields show whether zero is kept or wraps. Frames run back to back check that the generator keeps its state from one frame to the next. The write log and the done cycle expose writes out of order, writes to the padding, a wrong stride or a read latency slip. A stray `start` in mid-frame would restart seeding and produce a second `done`.

// File: rtl/heat_pkg.sv
package heat_pkg;

    localparam int CELL_W    = 8;
    localparam int ACC_W     = 10;
    localparam int RNG_W     = 16;
    localparam int SEED_BITS = 7;

    typedef logic [CELL_W-1:0] cell_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [RNG_W-1:0]  rng_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEED, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_WR, ST_DONE
    } phase_e;

    typedef enum logic [2:0] {
        TAP_SELF, TAP_DL, TAP_D, TAP_DR, TAP_DD
    } tap_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic rng_t rng_step(input rng_t s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic cell_t cool_down(input acc_t sum);
        acc_t avg;
        avg = sum >> 2;
        return (avg == '0) ? '0 : cell_t'(avg - 1'b1);
    endfunction

endpackage

// File: rtl/heat_rng.sv
module heat_rng
    import heat_pkg::*;
#(
    parameter rng_t INIT = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output rng_t state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= INIT;
        else if (advance)
            state <= rng_step(state);
    end
endmodule

// File: rtl/heat_walker.sv
module heat_walker
    import heat_pkg::*;
#(
    parameter int DIM_W  = 9,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_seed,
    input  logic              go_sweep,
    input  logic              advance,
    input  logic [DIM_W-1:0]  w,
    input  logic [DIM_W-1:0]  h,
    input  tap_e              tap,
    output logic [ADDR_W-1:0] addr,
    output logic              row_end,
    output logic [DIM_W-1:0]  row
);
    logic [DIM_W-1:0]  col;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] here;

    assign stride  = ADDR_W'(w) + 1'b1;
    assign here    = base + ADDR_W'(col);
    assign row_end = (col == w - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            col  <= DIM_W'(1);
            row  <= '0;
            base <= '0;
        end else if (go_seed) begin
            col  <= DIM_W'(1);
            row  <= h - 1'b1;
            base <= ADDR_W'(h - 1'b1) * stride;
        end else if (go_sweep) begin
            col  <= DIM_W'(1);
            row  <= '0;
            base <= '0;
        end else if (advance) begin
            if (row_end) begin
                col  <= DIM_W'(1);
                row  <= row + 1'b1;
                base <= base + stride;
            end else begin
                col  <= col + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (tap)
            TAP_DL:  addr = here + stride - 1'b1;
            TAP_D:   addr = here + stride;
            TAP_DR:  addr = here + stride + 1'b1;
            TAP_DD:  addr = here + (stride << 1);
            default: addr = here;
        endcase
    end
endmodule

// File: rtl/heat_cooler.sv
module heat_cooler
    import heat_pkg::*;
(
    input  acc_t  partial,
    input  cell_t last,
    output cell_t cooled
);
    acc_t total;
    assign total  = partial + acc_t'(last);
    assign cooled = cool_down(total);
endmodule

// File: rtl/heat_cascade_engine.sv
module heat_cascade_engine
    import heat_pkg::*;
#(
    parameter int MAX_W  = 319,
    parameter int MAX_H  = 79,
    parameter int DIM_W  = $clog2(max2(MAX_W, MAX_H) + 2),
    parameter int ADDR_W = $clog2((MAX_W + 1) * (MAX_H + 1))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata
);
    phase_e           phase, nxt;
    acc_t             acc;
    logic [DIM_W-1:0] w_q, h_q, w_use, h_use;
    logic             go_seed, go_sweep, step, rng_adv;
    logic             row_end, last_cell;
    logic [DIM_W-1:0] row;
    tap_e             tap;
    rng_t             rng_state;
    cell_t            cooled;

    assign w_use = (phase == ST_IDLE) ? cfg_width  : w_q;
    assign h_use = (phase == ST_IDLE) ? cfg_height : h_q;

    heat_rng u_rng (
        .clk(clk), .rst(rst), .advance(rng_adv), .state(rng_state)
    );

    heat_walker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst(rst), .go_seed(go_seed), .go_sweep(go_sweep),
        .advance(step), .w(w_use), .h(h_use), .tap(tap),
        .addr(mem_addr), .row_end(row_end), .row(row)
    );

    heat_cooler u_cool (
        .partial(acc), .last(mem_rdata), .cooled(cooled)
    );

    assign last_cell = row_end && (row == h_q - DIM_W'(2));
    assign done      = (phase == ST_DONE);

    always_comb begin
        nxt       = phase;
        go_seed   = 1'b0;
        go_sweep  = 1'b0;
        step      = 1'b0;
        rng_adv   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        tap       = TAP_SELF;
        unique case (phase)
            ST_IDLE: begin
                if (start) begin
                    go_seed = 1'b1;
                    nxt     = ST_SEED;
                end
            end
            ST_SEED: begin
                mem_we    = 1'b1;
                mem_wdata = cell_t'(rng_state[SEED_BITS-1:0]);
                rng_adv   = 1'b1;
                if (row_end) begin
                    go_sweep = 1'b1;
                    nxt      = ST_RD0;
                end else begin
                    step = 1'b1;
                end
            end
            ST_RD0: begin tap = TAP_DL; nxt = ST_RD1; end
            ST_RD1: begin tap = TAP_D;  nxt = ST_RD2; end
            ST_RD2: begin tap = TAP_DR; nxt = ST_RD3; end
            ST_RD3: begin tap = TAP_DD; nxt = ST_WR;  end
            ST_WR: begin
                mem_we    = 1'b1;
                mem_wdata = cooled;
                if (last_cell) begin
                    nxt = ST_DONE;
                end else begin
                    step = 1'b1;
                    nxt  = ST_RD0;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            acc   <= '0;
            w_q   <= '0;
            h_q   <= '0;
        end else begin
            phase <= nxt;
            if (phase == ST_IDLE && start) begin
                w_q <= cfg_width;
                h_q <= cfg_height;
            end
            unique case (phase)
                ST_RD1:         acc <= acc_t'(mem_rdata);
                ST_RD2, ST_RD3: acc <= acc + acc_t'(mem_rdata);
                default:        acc <= acc;
            endcase
        end
    end
endmodule

// File: rtl/heat_cascade_checker.sv
module heat_cascade_checker
    import heat_pkg::*;
#(
    parameter int DIM_W  = 9,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input phase_e            phase,
    input logic [DIM_W-1:0]  w_q
);
    // R8: done lasts exactly one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done is preceded by the frame's last write
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_we));

    // R9: a start during the sweep never restarts seeding
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (start && phase inside {ST_RD0, ST_RD1, ST_RD2, ST_RD3}) |=> phase != ST_SEED);

    // R3: column 0 is never written
    p_border_col_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && w_q != '0) |-> (int'(mem_addr) % (int'(w_q) + 1)) != 0);

    // R2: cooled or seeded values never reach 255
    p_cool_bound_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_wdata != 8'hFF);
endmodule

bind heat_cascade_engine heat_cascade_checker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .phase(phase), .w_q(w_q)
);

// File: tb/tb_heat_cascade_engine.sv
module tb_heat_cascade_engine;
    localparam int CLK_NS = 10;
    localparam int DIM_W  = 9;
    localparam int ADDR_W = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  cfg_width = '0;
    logic [DIM_W-1:0]  cfg_height = '0;
    logic              done;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_we;
    logic [7:0]        mem_rdata;

    int tests = 0;
    int fails = 0;

    logic [7:0] ram   [0:255];
    int         expv  [0:255];
    int         wlog  [0:255];
    int         wcnt;
    int         stray_addr;
    logic [15:0] ref_rng = 16'hACE1;

    always #(CLK_NS/2) clk = ~clk;

    heat_cascade_engine dut (
        .clk(clk), .rst(rst), .start(start), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .done(done), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // RAM model: one-cycle read latency, plus a write log
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_addr < 256) ram[mem_addr[7:0]] <= mem_wdata;
            else stray_addr = int'(mem_addr);
            if (wcnt < 256) wlog[wcnt] = int'(mem_addr);
            wcnt = wcnt + 1;
        end
        mem_rdata <= (mem_addr < 256) ? ram[mem_addr[7:0]] : 8'h00;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int kind);
        for (int i = 0; i < 256; i++) begin
            case (kind)
                0: ram[i] = 8'((i * 37 + 11) & 8'hFF);
                1: ram[i] = 8'h00;
                default: ram[i] = 8'hFF;
            endcase
        end
    endtask

    task automatic frame(input int w, input int h, input bit poke);
        int stride, cells, cnt, exp_cyc, n, sum, avg, idx, mism, lmis, dones;
        int order [0:255];
        stride = w + 1;
        cells  = (w - 1) * (h - 1);
        // expected contents and write order
        for (int i = 0; i < 256; i++) expv[i] = int'(ram[i]);
        n = 0;
        for (int x = 1; x <= w - 1; x++) begin
            idx = (h - 1) * stride + x;
            expv[idx] = int'(ref_rng[6:0]);
            ref_rng = {ref_rng[14:0], ref_rng[15] ^ ref_rng[13] ^ ref_rng[12] ^ ref_rng[10]};
            order[n] = idx; n++;
        end
        for (int y = 0; y <= h - 2; y++) begin
            for (int x = 1; x <= w - 1; x++) begin
                sum = expv[(y+1)*stride + x - 1] + expv[(y+1)*stride + x]
                    + expv[(y+1)*stride + x + 1] + expv[(y+2)*stride + x];
                avg = sum >> 2;
                idx = y * stride + x;
                expv[idx] = (avg > 0) ? avg - 1 : 0;
                order[n] = idx; n++;
            end
        end
        exp_cyc = (w - 1) + 5 * cells + 1;

        @(negedge clk);
        wcnt = 0;
        stray_addr = -1;
        cfg_width  = DIM_W'(w);
        cfg_height = DIM_W'(h);
        start = 1'b1;
        @(posedge clk);
        cnt = 0;
        dones = 0;
        while (cnt < 5000) begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
            if (poke && (cnt == w + 6 || cnt == w + 20)) start = 1'b1; // R9 stray starts
            if (done) begin dones++; break; end
        end
        chk(done === 1'b1, "R7 done cycle reached", cnt, exp_cyc);
        chk(cnt == exp_cyc, "R7 done cycle", cnt, exp_cyc);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle wide", int'(done), 0);
        for (int k = 0; k < 6 * w; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(dones == 1, "R9 single done per frame", dones, 1);
        chk(wcnt == n, "R6 write count", wcnt, n);
        chk(stray_addr == -1, "R3 no write past RAM model", stray_addr, -1);
        lmis = 0;
        for (int i = 0; i < n && i < 256; i++)
            if (wlog[i] != order[i]) begin
                if (lmis == 0) $display("FAIL R4/R6 write %0d: actual addr %0d expected %0d", i, wlog[i], order[i]);
                lmis++;
            end
        chk(lmis == 0, "R6 write order", lmis, 0);
        mism = 0;
        for (int i = 0; i < 256; i++)
            if (int'(ram[i]) != expv[i]) begin
                if (mism < 4) $display("FAIL R1/R2/R3/R5 addr %0d: actual %0d expected %0d", i, ram[i], expv[i]);
                mism++;
            end
        chk(mism == 0, "R1 R2 R3 R5 contents", mism, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wcnt = 0;
        repeat (4) @(negedge clk);
        // R10: reset state, idle without start
        chk(done === 1'b0, "R10 done low after reset", int'(done), 0);
        chk(mem_we === 1'b0, "R10 no write after reset", int'(mem_we), 0);
        chk(wcnt == 0, "R10 no writes while idle", wcnt, 0);

        fill(0); frame(6, 5, 1'b0);   // mixed values
        frame(6, 5, 1'b0);            // generator carries over (R5)
        fill(1); frame(4, 3, 1'b0);   // zero stays zero (R2)
        fill(2); frame(7, 4, 1'b1);   // 1020 sums (R1), stray start (R9)
        fill(0); frame(2, 2, 1'b0);   // smallest geometry

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule